// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous memory built around a late-write protocol. Address, chip select, global write enable and one write enable per 9-bit lane are captured on the rising clock edge. The data for a write does not arrive with its address. It is sampled on the following rising edge. The write then waits in a pending stage and is written into the storage array on a later cycle that does not need the array for a read. Reads go through an input register, a merge stage and an output register, so every read is pipelined.

While a write is still waiting in the pending stage, a read of the same word must still see it. A compare-and-merge bypass handles this. It takes each enabled lane of the read word from the pending write and every other lane from the array. The output has a drive-enable signal that models a tri-state pin and is controlled without the clock. A power-down input blocks new commands and switches the output drive off.

The memory takes a new command on every clock cycle and has no back-pressure, so its edge has no valid/ready handshake. The word is `LANES` lanes of `LANE_W` bits each. The depth is a parameter and can be kept small for simulation.

Top module: `lw_sram`

## Requirements
- R1: A write is accepted only if both `sel` and `wr_en` are high at the address edge. Only lanes whose `lane_we` bit is set are changed, where lane i occupies data bits [9i+8:9i]. Deselected cycles never write, whatever the state of `wr_en`.
- R2: The data for an accepted write is taken from `wdata` on the rising edge that comes one cycle after its address edge.
- R3: A read is a cycle with `sel` high and `wr_en` low. If its address is sampled at edge N, `rdata` holds the word from edge N+2 onward.
- R4: An accepted write stays pending until the next write or idle cycle, and a read cycle does not move it into the array. Every write is kept, including back-to-back writes.
- R5: If a read matches the address of a pending write, each lane enabled in that write comes from the pending data and every other lane comes from the array.
- R6: `rdata` changes only when a read result reaches the output register. Idle, deselected, write and blocked cycles leave it unchanged.
- R7: `rdata_oe` equals `oe && !pdn` at all times, without waiting for a clock edge.
- R8: A command whose address edge sees `pdn` high is ignored. It writes nothing and produces no read result.
- R9: While `rst_n` is low, `rdata` is zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control and output registers |
| addr | input | AW | Word address, sampled at the edge |
| sel | input | 1 | Synchronous chip select |
| wr_en | input | 1 | Global write enable, sampled with `sel` |
| lane_we | input | LANES | Per-lane write enables for the current write |
| wdata | input | DW | Write data, sampled one edge after its address |
| oe | input | 1 | Asynchronous output enable |
| pdn | input | 1 | Asynchronous power-down |
| rdata | output | DW | Registered read data |
| rdata_oe | output | 1 | Drive enable for `rdata` (low means high impedance) |

## Verification
The bench first fills the memory with back-to-back full-lane writes and reads every address back. This separates correct commit ordering from lost or misplaced writes. Next it tries all sixteen lane masks. Each masked write is followed at once by a read of the same word, which exercises the bypass merge. After an idle cycle the word is read again, which shows whether the array itself ended up with the same merged word. Deselected writes, power-down commands and output-enable changes are checked at the output pins. A long pseudo-random mix of reads, writes, idles and blocked cycles over eight addresses then exercises pending hits, misses and drains in every ordering.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import lw_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [LANES-1:0] lane_we,
  input  logic             pdn,
  output op_e              op,
  output logic [AW-1:0]    op_addr,
  output logic [LANES-1:0] op_mask
);
  op_e op_d;

  always_comb begin
    if (pdn || !sel) op_d = OP_IDLE;
    else if (wr_en)  op_d = OP_WRITE;
    else             op_d = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op      <= OP_IDLE;
      op_addr <= '0;
      op_mask <= '0;
    end else begin
      op      <= op_d;
      op_addr <= addr;
      op_mask <= lane_we;
    end
  end

  AST_PDN_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> (op == OP_IDLE)); // R8
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (op == OP_IDLE)); // R1
endmodule

// File: rtl/lw_late_write.sv
module lw_late_write
  import lw_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [AW-1:0]    op_addr,
  input  logic [LANES-1:0] op_mask,
  input  logic [DW-1:0]    wdata,
  output logic             pend_valid,
  output logic [AW-1:0]    pend_addr,
  output logic [LANES-1:0] pend_mask,
  output logic [DW-1:0]    pend_data,
  output logic             commit
);
  // The array is free for the pending write on every non-read cycle.
  assign commit = pend_valid && (op != OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_mask  <= '0;
      pend_data  <= '0;
    end else if (op == OP_WRITE) begin
      pend_valid <= 1'b1;
      pend_addr  <= op_addr;
      pend_mask  <= op_mask;
      pend_data  <= wdata;
    end else if (op == OP_IDLE) begin
      pend_valid <= 1'b0;
    end
  end

  AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> pend_valid); // R4
  AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> !pend_valid); // R4
  AST_READ_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ && pend_valid) |=> (pend_valid && $stable(pend_data))); // R4
  AST_DATA_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> (pend_data == $past(wdata))); // R2
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             commit,
  input  logic [AW-1:0]    pend_addr,
  input  logic [LANES-1:0] pend_mask,
  input  logic [DW-1:0]    pend_data,
  input  logic [AW-1:0]    op_addr,
  output logic [DW-1:0]    arr_rdata
);
  logic [AW-1:0] arr_addr;

  // 2:1 selector: the write address wins whenever a commit uses the port.
  assign arr_addr = commit ? pend_addr : op_addr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && pend_mask[g]) mem[arr_addr] <= pend_data[g*LANE_W +: LANE_W];
    end

    assign arr_rdata[g*LANE_W +: LANE_W] = mem[arr_addr];
  end
endmodule

// File: rtl/lw_read_path.sv
module lw_read_path
  import lw_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [AW-1:0]    op_addr,
  input  logic [DW-1:0]    arr_rdata,
  input  logic             pend_valid,
  input  logic [AW-1:0]    pend_addr,
  input  logic [LANES-1:0] pend_mask,
  input  logic [DW-1:0]    pend_data,
  output logic [DW-1:0]    dout
);
  logic          addr_hit;
  logic [DW-1:0] merged;
  logic [DW-1:0] rd_q;
  logic          rd_v;

  assign addr_hit = pend_valid && (pend_addr == op_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (addr_hit && pend_mask[g])
                                      ? pend_data[g*LANE_W +: LANE_W]
                                      : arr_rdata[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v <= 1'b0;
      rd_q <= '0;
      dout <= '0;
    end else begin
      rd_v <= (op == OP_READ);
      if (op == OP_READ) rd_q <= merged;
      if (rd_v)          dout <= rd_q;
    end
  end

  AST_FULL_HIT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ && addr_hit && (&pend_mask)) |=> (rd_q == $past(pend_data))); // R5
  AST_HOLD_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_READ) |-> ##2 $stable(dout)); // R6
  AST_READ_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |-> ##2 (dout == $past(merged, 2))); // R3
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [LANES-1:0] lane_we,
  input  logic [DW-1:0]    wdata,
  input  logic             oe,
  input  logic             pdn,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);
  op_e              op;
  logic [AW-1:0]    op_addr;
  logic [LANES-1:0] op_mask;
  logic             pend_valid;
  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_mask;
  logic [DW-1:0]    pend_data;
  logic             commit;
  logic [DW-1:0]    arr_rdata;

  lw_cmd_stage #(.AW(AW), .LANES(LANES)) i_cmd (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .wr_en(wr_en),
    .lane_we(lane_we), .pdn(pdn), .op(op), .op_addr(op_addr), .op_mask(op_mask)
  );

  lw_late_write #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_lw (
    .clk(clk), .rst_n(rst_n), .op(op), .op_addr(op_addr), .op_mask(op_mask),
    .wdata(wdata), .pend_valid(pend_valid), .pend_addr(pend_addr),
    .pend_mask(pend_mask), .pend_data(pend_data), .commit(commit)
  );

  lw_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_arr (
    .clk(clk), .commit(commit), .pend_addr(pend_addr), .pend_mask(pend_mask),
    .pend_data(pend_data), .op_addr(op_addr), .arr_rdata(arr_rdata)
  );

  lw_read_path #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_rd (
    .clk(clk), .rst_n(rst_n), .op(op), .op_addr(op_addr), .arr_rdata(arr_rdata),
    .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_mask(pend_mask),
    .pend_data(pend_data), .dout(rdata)
  );

  assign rdata_oe = oe & ~pdn;

  always_comb begin
    if (rst_n === 1'b0) AST_RESET_CLEAR: assert (rdata == '0 && !pend_valid); // R9
  end
endmodule

// File: tb/test_lw_sram.sv
`timescale 1ns/1ps
module test_lw_sram;
  localparam int DEPTH  = 16;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int AW     = $clog2(DEPTH);
  localparam int DW     = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic             sel = 1'b0;
  logic             wr_en = 1'b0;
  logic [LANES-1:0] lane_we = '0;
  logic [DW-1:0]    wdata = '0;
  logic             oe = 1'b1;
  logic             pdn = 1'b0;
  logic [DW-1:0]    rdata;
  logic             rdata_oe;

  always #5 clk = ~clk;

  lw_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_lw_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .wr_en(wr_en),
    .lane_we(lane_we), .wdata(wdata), .oe(oe), .pdn(pdn),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [DW-1:0]    mdl [DEPTH];
  logic             prev_w = 1'b0;
  logic [AW-1:0]    prev_a = '0;
  logic [LANES-1:0] prev_m = '0;
  logic [DW-1:0]    prev_d = '0;
  logic             p1_v = 1'b0, p2_v = 1'b0;
  logic [DW-1:0]    p1_e = '0, p2_e = '0;
  string            p1_t = "", p2_t = "";
  logic [DW-1:0]    last_out = '0;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // One clock: drive a command, feed the data of the previous write, check output.
  task automatic step(input logic s, input logic w, input logic [LANES-1:0] m,
                      input logic [AW-1:0] a, input logic pd, input logic o,
                      input string tag);
    logic          cur_rd;
    logic [DW-1:0] cur_e;
    seed = lcg(seed);
    sel = s; wr_en = w; lane_we = m; addr = a; pdn = pd; oe = o;
    wdata = prev_w ? prev_d : {seed[3:0], seed};
    if (prev_w)
      for (int g = 0; g < LANES; g++)
        if (prev_m[g]) mdl[prev_a][g*LANE_W +: LANE_W] = prev_d[g*LANE_W +: LANE_W];
    #1;
    chk("R7", {{(DW-1){1'b0}}, rdata_oe}, {{(DW-1){1'b0}}, (o && !pd)});
    cur_rd = s && !w && !pd;
    cur_e  = mdl[a];
    prev_w = s && w && !pd;
    prev_a = a;
    prev_m = m;
    seed   = lcg(seed);
    prev_d = {seed[7:4], seed ^ 32'h5a5a_a5a5};
    @(posedge clk);
    #1;
    if (p2_v) chk(p2_t, rdata, p2_e);
    else      chk("R6", rdata, last_out);
    last_out = rdata;
    p2_v = p1_v; p2_e = p1_e; p2_t = p1_t;
    p1_v = cur_rd; p1_e = cur_e; p1_t = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, 1'b0, 1'b1, "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state at the pins
    chk("R9", rdata, '0);
    chk("R9", {{(DW-1){1'b0}}, rdata_oe}, {{(DW-1){1'b0}}, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R2/R4: back-to-back full-lane fill of every word
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b1, 4'hF, AW'(a), 1'b0, 1'b1, "R2");
    idle(1);
    // R3: read back all words with two-edge latency
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, '0, AW'(a), 1'b0, 1'b1, "R3");
    idle(3);

    // R1/R5: every lane mask, immediate read (bypass) then committed read
    for (int m = 0; m < 16; m++) begin
      step(1'b1, 1'b1, 4'(m), AW'(m % DEPTH), 1'b0, 1'b1, "R1");
      step(1'b1, 1'b0, '0, AW'(m % DEPTH), 1'b0, 1'b1, "R5");
      step(1'b1, 1'b0, '0, AW'(m % DEPTH), 1'b0, 1'b1, "R5");
      idle(1);
      step(1'b1, 1'b0, '0, AW'(m % DEPTH), 1'b0, 1'b1, "R1");
    end
    idle(3);

    // R1: write enable without select changes nothing
    step(1'b0, 1'b1, 4'hF, AW'(3), 1'b0, 1'b1, "R1");
    idle(1);
    step(1'b1, 1'b0, '0, AW'(3), 1'b0, 1'b1, "R1");
    idle(3);

    // R8: commands during power-down are dropped; R7 drive goes off
    step(1'b1, 1'b1, 4'hF, AW'(5), 1'b1, 1'b1, "R8");
    idle(1);
    step(1'b1, 1'b0, '0, AW'(5), 1'b0, 1'b1, "R8");
    step(1'b1, 1'b0, '0, AW'(6), 1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, '0, AW'(7), 1'b0, 1'b0, "R7");
    idle(3);

    // R4/R5: pseudo-random mix over a narrow address range
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      seed = lcg(seed);
      r = seed;
      step(r[0] | r[1], r[2], r[7:4], AW'(r[10:8]), (r[15:12] == 4'h0), r[16],
           r[2] ? "R4" : "R5");
    end
    idle(4);
    finish_run();
  end
endmodule